// File: doc/BRIEF.md
# Ten-Row Carry-Save Reduction Adder

This block adds ten equally weighted 38-bit rows in one pass and registers the result. It is the accumulation back end of a wide multiplier: the rows arrive already shifted into position and sign-extended, and the block returns their total modulo 2^38. Because every row uses two's complement, the same result serves both signed and unsigned use.

The reduction runs in three levels of carry-save compression. Each level is built from rows of four-input compressor cells. Level one uses two compressor rows to turn rows 0 to 7 into four vectors. Level two uses one compressor row to turn four of the six remaining vectors into two. Level three uses one compressor row to merge those two with rows 8 and 9. A lookahead adder then resolves the last sum and carry vectors.

Inside a compressor row, each cell passes a side carry to its neighbour one bit up. That side carry never depends on the side carry coming in, so no ripple forms along the row. The whole path from the input rows to the output register is combinational and fits within one clock cycle.

Top module: `csa42_reduce_top`

## Requirements
- R1: On each rising edge with reset low, `sum_o` takes the sum of the ten 38-bit slices of `rows_i` sampled at that edge, modulo 2^38. Row k occupies bits [38k+37:38k].
- R2: Reset is synchronous and active high. A rising edge with `rst` high sets `sum_o` to zero, whatever `rows_i` holds.
- R3: Carries above bit 37 are dropped. For example, ten rows of all ones give 2^38 − 10, and ten rows of 2^37 − 1 give (10·(2^37 − 1)) mod 2^38.
- R4: When all ten rows are zero, the next output is zero.
- R5: Every row index carries the same weight. A single nonzero row at any index 0 to 9, with the other nine rows zero, appears unchanged at the output.
- R6: While `rows_i` is held constant and reset stays low, `sum_o` does not change from one cycle to the next.
- R7: Rows holding two's-complement negatives add correctly. A row x paired with a row holding −x cancels to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset that clears the output |
| rows_i | input | 380 | Ten packed 38-bit addend rows; row k is at bits [38k+37:38k] |
| sum_o | output | 38 | Registered sum of the ten rows, modulo 2^38 |

## Verification
The assertions assume that `rows_i` is valid and settled at every rising edge with reset low. They also assume that reset is high at the first edge, so that the output register starts from a known value. The bench meets both conditions. It holds reset through the first edges, and it changes `rows_i` and `rst` only on falling edges, half a cycle away from the sampling edge. The stimulus covers extreme values, single nonzero rows, cancelling signed pairs, held inputs and random rows, and each result is read one cycle after its inputs were applied.

// File: rtl/csa42_pkg.sv
package csa42_pkg;
  localparam int ROW_W  = 38;
  localparam int N_ROWS = 10;

  // Reference total of packed rows, used only by the checker.
  function automatic logic [ROW_W-1:0] ref_total(input logic [N_ROWS*ROW_W-1:0] rows);
    logic [ROW_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < N_ROWS; k++) acc = acc + rows[k*ROW_W +: ROW_W];
    return acc;
  endfunction
endpackage

// File: rtl/csa42_cell.sv
// One 4-2 compressor bit: s + 2*cy + 2*xo == a + b + c + d + xi.
// xo depends only on a, b, c, so side carries never ripple.
module csa42_cell (
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  input  logic xi,
  output logic s,
  output logic cy,
  output logic xo
);
  logic t;
  always_comb begin
    t  = a ^ b ^ c;
    xo = (a & b) | (a & c) | (b & c);
    s  = t ^ d ^ xi;
    cy = (t & d) | (t & xi) | (d & xi);
  end
endmodule

// File: rtl/csa42_row.sv
// A row of compressor cells; side carries chain upward, bit 0 side input is zero.
// The top bit keeps only its sum, so carries past the MSB are dropped.
module csa42_row #(
  parameter int W = 38
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] s,
  output logic [W-1:0] cy
);
  logic [W-1:0] xin;
  logic [W-2:0] xout;
  logic [W-2:0] cbit;

  assign xin = {xout, 1'b0};
  assign cy  = {cbit, 1'b0};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_full
      csa42_cell u_cell (
        .a(a[i]), .b(b[i]), .c(c[i]), .d(d[i]), .xi(xin[i]),
        .s(s[i]), .cy(cbit[i]), .xo(xout[i])
      );
    end else begin : g_msb
      assign s[i] = a[i] ^ b[i] ^ c[i] ^ d[i] ^ xin[i];
    end
  end
endmodule

// File: rtl/csa42_cla.sv
// Block carry-lookahead adder: full lookahead inside each group,
// group generate/propagate passed between groups. Output is mod 2^W.
module csa42_cla #(
  parameter int W  = 38,
  parameter int GW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  localparam int NG = (W + GW - 1) / GW;

  logic [NG-1:0] gcin;
  assign gcin[0] = 1'b0;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int LO = k * GW;
    localparam int BW = ((W - LO) < GW) ? (W - LO) : GW;
    logic [BW-1:0] pp, cc;

    assign pp = a[LO +: BW] ^ b[LO +: BW];

    always_comb begin
      for (int j = 0; j < BW; j++) begin
        cc[j] = 1'b0;
        for (int i = 0; i <= j; i++) begin
          logic t;
          t = (i == 0) ? gcin[k] : (a[LO+i-1] & b[LO+i-1]);
          for (int m = i; m < j; m++) t = t & pp[m];
          cc[j] = cc[j] | t;
        end
      end
    end

    assign s[LO +: BW] = pp ^ cc;

    if (k < NG - 1) begin : g_next
      logic grp_g;
      always_comb begin
        grp_g = 1'b0;
        for (int i = 0; i < BW; i++) begin
          logic t;
          t = a[LO+i] & b[LO+i];
          for (int m = i + 1; m < BW; m++) t = t & pp[m];
          grp_g = grp_g | t;
        end
      end
      assign gcin[k+1] = grp_g | ((&pp) & gcin[k]);
    end
  end
endmodule

// File: rtl/csa42_reduce_top.sv
module csa42_reduce_top #(
  parameter int W  = csa42_pkg::ROW_W,
  parameter int GW = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [csa42_pkg::N_ROWS*W-1:0]     rows_i,
  output logic [W-1:0]                       sum_o
);
  localparam int NR = csa42_pkg::N_ROWS;

  logic [W-1:0] row [NR];
  for (genvar k = 0; k < NR; k++) begin : g_unpack
    assign row[k] = rows_i[k*W +: W];
  end

  // Level 1: two compressor rows on rows 0..7
  logic [W-1:0] l1_s [2];
  logic [W-1:0] l1_c [2];
  for (genvar q = 0; q < 2; q++) begin : g_lvl1
    csa42_row #(.W(W)) u_row (
      .a(row[4*q]), .b(row[4*q+1]), .c(row[4*q+2]), .d(row[4*q+3]),
      .s(l1_s[q]), .cy(l1_c[q])
    );
  end

  // Level 2: one compressor row on the four level-1 vectors
  logic [W-1:0] l2_s, l2_c;
  csa42_row #(.W(W)) u_lvl2 (
    .a(l1_s[0]), .b(l1_c[0]), .c(l1_s[1]), .d(l1_c[1]),
    .s(l2_s), .cy(l2_c)
  );

  // Level 3: merge with untouched rows 8 and 9
  logic [W-1:0] l3_s, l3_c;
  csa42_row #(.W(W)) u_lvl3 (
    .a(l2_s), .b(l2_c), .c(row[8]), .d(row[9]),
    .s(l3_s), .cy(l3_c)
  );

  logic [W-1:0] total;
  csa42_cla #(.W(W), .GW(GW)) u_cla (
    .a(l3_s), .b(l3_c), .s(total)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_o <= '0;
    else     sum_o <= total;
  end
endmodule

module csa42_reduce_chk #(
  parameter int W = csa42_pkg::ROW_W
) (
  input logic                           clk,
  input logic                           rst,
  input logic [csa42_pkg::N_ROWS*W-1:0] rows_i,
  input logic [W-1:0]                   sum_o
);
  assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sum_o == $past(csa42_pkg::ref_total(rows_i)));

  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> sum_o == '0);

  assert_zero_in_R4: assert property (@(posedge clk) disable iff (rst)
    (rows_i == '0) |=> sum_o == '0);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $stable(rows_i)) |=> $stable(sum_o));
endmodule

bind csa42_reduce_top csa42_reduce_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .rows_i(rows_i), .sum_o(sum_o)
);

// File: tb/csa42_reduce_top_tb.sv
module csa42_reduce_top_tb;
  localparam int W  = 38;
  localparam int NR = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NR*W-1:0]   rows_i = '0;
  logic [W-1:0]      sum_o;

  int n_cmp = 0;
  int n_bad = 0;

  logic [W-1:0] stim [NR];
  logic [W-1:0] exp_q [$];
  string        tag_q [$];

  always #4 clk = ~clk;

  csa42_reduce_top u_dut (.clk(clk), .rst(rst), .rows_i(rows_i), .sum_o(sum_o));

  function automatic logic [W-1:0] rnd38();
    return W'({$urandom, $urandom});
  endfunction

  task automatic clear_stim();
    for (int k = 0; k < NR; k++) stim[k] = '0;
  endtask

  // Compare pending result, then drive the next vector on the falling edge.
  task automatic step(input bit r, input string tag);
    logic [W-1:0] e;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      logic [W-1:0] ev;
      string        et;
      ev = exp_q.pop_front();
      et = tag_q.pop_front();
      n_cmp++;
      if (sum_o !== ev) begin
        n_bad++;
        $display("FAIL %s: sum_o=%h expected=%h", et, sum_o, ev);
      end
    end
    rst = r;
    e = '0;
    for (int k = 0; k < NR; k++) begin
      rows_i[k*W +: W] = stim[k];
      e = e + stim[k];
    end
    if (r) e = '0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_stim();
    for (int k = 0; k < NR; k++) stim[k] = rnd38();
    step(1'b1, "R2 reset with nonzero rows");
    step(1'b1, "R2 reset held");

    clear_stim();
    step(1'b0, "R4 all rows zero");

    for (int k = 0; k < NR; k++) stim[k] = '1;
    step(1'b0, "R3 all ones wrap");

    for (int k = 0; k < NR; k++) stim[k] = {1'b0, {(W-1){1'b1}}};
    step(1'b0, "R3 max positive wrap");

    for (int k = 0; k < NR; k++) stim[k] = {1'b1, {(W-1){1'b0}}};
    step(1'b0, "R3 most negative rows");

    for (int k = 0; k < NR; k++) begin
      clear_stim();
      stim[k] = rnd38();
      step(1'b0, $sformatf("R5 single row %0d", k));
    end

    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < NR; k += 2) begin
        stim[k]   = rnd38();
        stim[k+1] = -stim[k];
      end
      step(1'b0, "R7 cancelling signed pairs");
    end

    for (int n = 0; n < 6; n++) begin
      for (int k = 0; k < NR; k++) stim[k] = W'(-(k + n + 1));
      step(1'b0, "R7 small negatives");
    end

    for (int k = 0; k < NR; k++) stim[k] = rnd38();
    for (int n = 0; n < 5; n++) step(1'b0, "R6 inputs held");

    for (int k = 0; k < NR; k++) stim[k] = rnd38();
    step(1'b0, "R1 before mid reset");
    step(1'b1, "R2 mid-stream reset");

    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < NR; k++) begin
        case ($urandom % 4)
          0: stim[k] = '1;
          1: stim[k] = rnd38() & W'({$urandom});
          default: stim[k] = rnd38();
        endcase
      end
      step(1'b0, "R1 random rows");
    end

    clear_stim();
    step(1'b0, "R4 final zero");
    step(1'b0, "R4 flush");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule